// File: doc/BRIEF.md
# Command-Driven Binary Field Arithmetic Unit

This block is a small arithmetic engine for elements of GF(2^m) in polynomial basis, reduced by a trinomial x^m + x^k + 1. It keeps sixteen m-bit field elements in an internal register file. A host drives it through one byte-wide write port that carries both commands and operand data, and one byte-wide read port. Every operation writes its result back into the register file. A chain of additions, squarings and products therefore moves no operand over the narrow bus. Only the initial loads and the final reads use it.

A command is two bytes. The first byte carries the operation and the destination register. The second byte names two source registers. Addition and squaring finish at the edge that takes the second byte. Multiplication goes to a bit-serial multiplier instance, and the block raises `busy` for the length of that product. A separate command streams a register out through the read port. Inversion and any sequencing at the curve level are left to the host.

Top module: `gfcp_top`

## Requirements
- R1: After reset, `busy`, `err` and `rd_data` are 0 and every register holds the zero element.
- R2: Command byte 1 holds the opcode in bits [7:4] and the destination register in bits [3:0]. Command byte 2 holds source A in bits [7:4] and source B in bits [3:0].
- R3: Opcode 4 (load) takes the next ceil(m/8) write bytes, least significant first, as the new value of the destination. Bits at position m and above are discarded.
- R4: Opcode 5 (read) copies source A into an output buffer. `rd_data` shows its least significant byte, and each cycle with `rd_en` high advances to the next byte. The buffer does not change on cycles with neither `rd_en` nor `wr_en`.
- R5: Opcode 1 (add) writes source A XOR source B to the destination at the edge that takes the second command byte.
- R6: Opcode 2 (square) writes the reduced square of source A to the destination at the edge that takes the second command byte. Source B is ignored.
- R7: Opcode 3 (multiply) writes the reduced product of sources A and B to the destination. `busy` rises in the cycle after the second byte and stays high for exactly m cycles.
- R8: A write byte that arrives while `busy` is high is dropped and does not advance command decoding. It sets `err`, which stays set until reset.
- R9: Opcodes 0 and 6 through 15 change no register.
- R10: The destination may equal a source. The result is computed from the values the sources held before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write byte strobe |
| wr_data | input | 8 | Command or load data byte |
| rd_en | input | 1 | Advance output buffer by one byte |
| rd_data | output | 8 | Current output buffer byte |
| busy | output | 1 | Multiplication in progress |
| err | output | 1 | Sticky flag for a byte dropped while busy |

## Verification
The bench builds the block with m = 11 and k = 2. That field has 2048 elements, so squaring is checked over every element and each of the 2048 elements is multiplied by a varying partner. The result is read back and compared with a carry-less product reduced in the bench. Eleven bits span two bytes, so the byte ordering of load and read and the truncation above bit m are exercised. The short multiply makes the exact busy length and a byte dropped during a product easy to observe.

// File: rtl/gfcp_pkg.sv
package gfcp_pkg;

    localparam int NREG   = 16;
    localparam int REG_AW = 4;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_ADD  = 4'd1,
        OP_SQR  = 4'd2,
        OP_MUL  = 4'd3,
        OP_LOAD = 4'd4,
        OP_READ = 4'd5
    } opcode_t;

    typedef enum logic [1:0] {
        PH_OP   = 2'd0,
        PH_SRC  = 2'd1,
        PH_LOAD = 2'd2
    } phase_t;

    typedef struct packed {
        logic [3:0]        op;
        logic [REG_AW-1:0] dst;
    } cmd_head_t;

endpackage

// File: rtl/gfcp_square.sv
module gfcp_square #(
    parameter int DEG = 113,
    parameter int TAP = 9
) (
    input  logic [DEG-1:0] a,
    output logic [DEG-1:0] y
);
    localparam int WIDE = 2 * DEG - 1;

    logic [WIDE-1:0] t;

    always_comb begin
        t = '0;
        for (int i = 0; i < DEG; i++) begin
            t[2 * i] = a[i];
        end
        for (int i = WIDE - 1; i >= DEG; i--) begin
            if (t[i]) begin
                t[i - DEG + TAP] = ~t[i - DEG + TAP];
                t[i - DEG]       = ~t[i - DEG];
                t[i]             = 1'b0;
            end
        end
        y = t[DEG-1:0];
    end
endmodule

// File: rtl/gfcp_mul.sv
module gfcp_mul #(
    parameter int DEG = 113,
    parameter int TAP = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [DEG-1:0] a,
    input  logic [DEG-1:0] b,
    output logic           busy,
    output logic           done,
    output logic [DEG-1:0] p
);
    localparam int CNTW = (DEG > 2) ? $clog2(DEG) : 1;
    localparam logic [DEG-1:0] LOWPOLY = (DEG'(1) << TAP) | DEG'(1);

    logic            run;
    logic [CNTW-1:0] cnt;
    logic [DEG-1:0]  acc, aq, bq;
    logic [DEG-1:0]  xt, nxt;

    always_comb begin
        xt  = {acc[DEG-2:0], 1'b0} ^ (acc[DEG-1] ? LOWPOLY : '0);
        nxt = xt ^ (bq[DEG-1] ? aq : '0);
    end

    assign busy = run;
    assign done = run && (cnt == '0);
    assign p    = nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
            acc <= '0;
            aq  <= '0;
            bq  <= '0;
        end else if (run) begin
            acc <= nxt;
            bq  <= {bq[DEG-2:0], 1'b0};
            cnt <= cnt - 1'b1;
            if (cnt == '0) run <= 1'b0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= CNTW'(DEG - 1);
            acc <= '0;
            aq  <= a;
            bq  <= b;
        end
    end
endmodule

// File: rtl/gfcp_top.sv
module gfcp_top
    import gfcp_pkg::*;
#(
    parameter int DEG = 113,
    parameter int TAP = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       busy,
    output logic       err
);
    localparam int NB  = (DEG + 7) / 8;
    localparam int BW  = NB * 8;
    localparam int LCW = $clog2(NB + 1);

    logic [DEG-1:0]    rf [NREG];
    phase_t            phase;
    cmd_head_t         head;
    logic [LCW-1:0]    ld_cnt;
    logic [BW-1:0]     ld_buf, ld_next;
    logic [BW-1:0]     obuf;
    logic              err_q;

    logic [REG_AW-1:0] src_a, src_b;
    logic [DEG-1:0]    opa, opb, sq_y, mul_p;
    logic              mul_busy, mul_done, mul_start, accept;

    assign src_a   = wr_data[7:4];
    assign src_b   = wr_data[3:0];
    assign opa     = rf[src_a];
    assign opb     = rf[src_b];
    assign accept  = wr_en && !mul_busy;
    assign mul_start = accept && (phase == PH_SRC) && (head.op == OP_MUL);
    assign ld_next = (ld_buf >> 8) | (BW'(wr_data) << (BW - 8));

    gfcp_square #(.DEG(DEG), .TAP(TAP)) u_sq (
        .a (opa),
        .y (sq_y)
    );

    gfcp_mul #(.DEG(DEG), .TAP(TAP)) u_mul (
        .clk   (clk),
        .rst   (rst),
        .start (mul_start),
        .a     (opa),
        .b     (opb),
        .busy  (mul_busy),
        .done  (mul_done),
        .p     (mul_p)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) rf[i] <= '0;
            phase  <= PH_OP;
            head   <= '0;
            ld_cnt <= '0;
            ld_buf <= '0;
            obuf   <= '0;
            err_q  <= 1'b0;
        end else begin
            if (wr_en && mul_busy) err_q <= 1'b1;
            if (rd_en) obuf <= obuf >> 8;
            if (mul_done) rf[head.dst] <= mul_p;
            if (accept) begin
                unique case (phase)
                    PH_OP: begin
                        head  <= wr_data;
                        phase <= PH_SRC;
                    end
                    PH_SRC: begin
                        phase <= PH_OP;
                        case (head.op)
                            OP_ADD:  rf[head.dst] <= opa ^ opb;
                            OP_SQR:  rf[head.dst] <= sq_y;
                            OP_LOAD: begin
                                phase  <= PH_LOAD;
                                ld_cnt <= '0;
                            end
                            OP_READ: obuf <= BW'(opa);
                            default: ;
                        endcase
                    end
                    PH_LOAD: begin
                        ld_buf <= ld_next;
                        if (ld_cnt == LCW'(NB - 1)) begin
                            rf[head.dst] <= ld_next[DEG-1:0];
                            phase        <= PH_OP;
                        end else begin
                            ld_cnt <= ld_cnt + 1'b1;
                        end
                    end
                    default: phase <= PH_OP;
                endcase
            end
        end
    end

    assign rd_data = obuf[7:0];
    assign busy    = mul_busy;
    assign err     = err_q;
endmodule

// File: rtl/gfcp_chk.sv
module gfcp_chk #(
    parameter int DEG = 113
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       busy,
    input logic       err
);
    localparam int BCW = $clog2(DEG + 1) + 1;

    logic [BCW-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (rst) bcnt <= '0;
        else     bcnt <= busy ? bcnt + 1'b1 : '0;
    end

    // R7: busy lasts exactly DEG cycles
    a_r7_busy_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> bcnt == BCW'(DEG));

    a_r7_busy_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> bcnt < BCW'(DEG));

    // R7: busy only follows an accepted write byte
    a_r7_busy_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_en));

    // R8: a byte written while busy sets the flag
    a_r8_err_set: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> err);

    // R8: the flag is sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R4: output byte holds without rd_en or wr_en
    a_r4_rd_hold: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !wr_en) |=> $stable(rd_data));
endmodule

bind gfcp_top gfcp_chk #(.DEG(DEG)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .busy    (busy),
    .err     (err)
);

// File: tb/test_gfcp_top.sv
module test_gfcp_top;
    localparam int DEG = 11;
    localparam int TAP = 2;
    localparam int NB  = (DEG + 7) / 8;
    localparam int MASK = (1 << DEG) - 1;

    logic       clk = 0;
    logic       rst = 1;
    logic       wr_en = 0;
    logic [7:0] wr_data = 0;
    logic       rd_en = 0;
    logic [7:0] rd_data;
    logic       busy, err;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    gfcp_top #(.DEG(DEG), .TAP(TAP)) i_gfcp_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .busy(busy), .err(err)
    );

    function automatic int ref_reduce(input int t);
        int r = t;
        for (int i = 2 * DEG - 2; i >= DEG; i--)
            if ((r >> i) & 1) r = r ^ (1 << i) ^ (1 << (i - DEG + TAP)) ^ (1 << (i - DEG));
        return r;
    endfunction

    function automatic int ref_mul(input int a, input int b);
        int t = 0;
        for (int i = 0; i < DEG; i++)
            if ((b >> i) & 1) t = t ^ (a << i);
        return ref_reduce(t);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1; wr_data = b;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic cmd(input int op, input int dst, input int sa, input int sb);
        put(8'((op << 4) | dst));
        put(8'((sa << 4) | sb));
    endtask

    task automatic load(input int dst, input int val);
        cmd(4, dst, 0, 0);
        for (int j = 0; j < NB; j++) put(8'(val >> (8 * j)));
    endtask

    task automatic readreg(input int src, output int val);
        cmd(5, 0, src, 0);
        val = 0;
        for (int j = 0; j < NB; j++) begin
            val = val | (int'(rd_data) << (8 * j));
            rd_en = 1;
            @(negedge clk);
            rd_en = 0;
        end
    endtask

    task automatic mulwait(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int v, a, b, n;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 err", err, 0);
        chk("R1 rd_data", rd_data, 0);
        readreg(15, v);
        chk("R1 reg zero", v, 0);

        // R3 R4 load and read, byte order and truncation
        for (int i = 0; i < 64; i++) begin
            a = (i * 16'h2F5 + 16'h1C3) & 16'hFFFF;
            load(3, a);
            readreg(3, v);
            chk("R3 R4 load/read", v, a & MASK);
        end
        load(3, 16'hFFFF);
        readreg(3, v);
        chk("R3 truncation", v, MASK);

        // R2 R5 add with field positions
        for (int i = 0; i < 256; i++) begin
            a = (i * 173 + 9) & MASK;
            b = (i * 611 + 1000) & MASK;
            load(1, a);
            load(2, b);
            cmd(1, 4, 1, 2);
            readreg(4, v);
            chk("R2 R5 add", v, a ^ b);
        end
        cmd(1, 1, 1, 1);
        readreg(1, v);
        chk("R10 in-place add", v, 0);

        // R6 square, every element, source B ignored
        for (int i = 0; i <= MASK; i++) begin
            load(6, i);
            cmd(2, 7, 6, 15);
            readreg(7, v);
            chk("R6 square", v, ref_mul(i, i));
        end

        // R7 multiply over every element
        for (int i = 0; i <= MASK; i++) begin
            a = i;
            b = (i * 37 + 5) & MASK;
            load(8, a);
            load(9, b);
            cmd(3, 10, 8, 9);
            mulwait(n);
            if (i == 0 || i == MASK) chk("R7 busy length", n, DEG);
            readreg(10, v);
            chk("R7 multiply", v, ref_mul(a, b));
        end

        // R10 in-place chain: r8 = r8*r9, r8 = r8^2, r8 = r8+r9
        load(8, 11'h5A3);
        load(9, 11'h1F0);
        cmd(3, 8, 8, 9);
        mulwait(n);
        cmd(2, 8, 8, 0);
        cmd(1, 8, 8, 9);
        a = ref_mul(11'h5A3, 11'h1F0);
        a = ref_mul(a, a) ^ 11'h1F0;
        readreg(8, v);
        chk("R10 chain", v, a);

        // R8 byte dropped during busy
        chk("R8 err clear before", err, 0);
        load(11, 11'h3C5);
        load(12, 11'h0A7);
        load(13, 11'h111);
        cmd(3, 14, 11, 12);
        put(8'h1D);          // would start ADD into r13 if taken
        chk("R8 err set", err, 1);
        mulwait(n);
        readreg(14, v);
        chk("R8 product intact", v, ref_mul(11'h3C5, 11'h0A7));
        readreg(13, v);
        chk("R8 dropped byte no effect", v, 11'h111);
        chk("R8 err sticky", err, 1);

        // R9 unused opcodes change nothing
        load(5, 11'h2B6);
        load(2, 11'h7FF);
        cmd(0, 5, 2, 2);
        cmd(6, 5, 2, 2);
        cmd(15, 5, 2, 2);
        readreg(5, v);
        chk("R9 nop/unused", v, 11'h2B6);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule